// File: doc/BRIEF.md
# Reaction-Time Quiz Controller

This block sequences a timed mental-arithmetic trial. Each trial begins with the display dark for two seconds. The controller then asks an external generator for a fresh pair of octal digits, shows them, and restarts an external decisecond timer. The user adds the two digits, sets the 4-bit answer switches and raises a submit switch. A correct answer freezes the timer and puts the reaction time on the display. A wrong answer shows error code 1. If no submission arrives within eight seconds, error code 2 is shown instead. Once the outcome has been cleared, the next trial begins.

The controller is a Moore machine: every output is decoded from the registered state alone. The answer and submit switches come straight from mechanical contacts, so they can bounce. The machine handles this with settle states built on one shared cycle counter. After submit first rises, the answer is read only once a fixed settle interval has passed. Leaving an outcome requires submit to stay low for that same interval without a break. The two error cases are cleared in different ways. Error 1 clears when submit falls. Error 2 needs submit to rise and then fall.

Top module: `quiz_timer_ctrl`

## Requirements
- R1: In the first cycle after reset, `tmr_clear` is 1 and all other outputs are 0 (`err_code` = 0). The reset state has the all-zero encoding.
- R2: The timer runs while the display is blank. `pair_req` is raised only after `elapsed` has reached `BLANK_DS` (20 deciseconds by default). `digits_show` stays 0 during the blank phase.
- R3: `pair_req` is a one-cycle pulse that coincides with `tmr_clear`. In the next cycle `digits_show` and `tmr_run` are both 1, so timing starts when the digits appear.
- R4: Submit is honoured only while the digits are shown. The answer is compared once, `SETTLE_CYC` cycles after submit was first seen high. The comparison is against `pair_in[5:3] + pair_in[2:0]`, a 4-bit sum from 0 to 14. Answer values present during the settle interval have no effect.
- R5: A correct answer stops the timer (`tmr_run` = 0 and `tmr_clear` = 0) and raises `time_show` with `err_code` = 0. The frozen `elapsed` value stays on display until submit is released.
- R6: A wrong answer gives `err_code` = 1 with `time_show` = 0. The error ends once submit has stayed low for `SETTLE_CYC` cycles.
- R7: If `elapsed` reaches `TIMEOUT_DS` (80 by default) while the digits are shown and no submit is present, `err_code` becomes 2.
- R8: Error 2 persists until submit has been raised and then held low for `SETTLE_CYC` cycles. Raising submit alone does not clear it.
- R9: After an outcome clears, the controller pulses `tmr_clear` and re-enters the blank phase, with `err_code` = 0 and `time_show` = 0.
- R10: A return of submit to 1 before the low settle interval completes restarts that interval, and the outcome display is kept. Bounce on submit during the high settle interval is ignored.
- R11: `tmr_clear` and `tmr_run` are never 1 together. `err_code` is never 3. Error code encoding: 0 none, 1 wrong answer, 2 timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_in | input | 6 | Digit pair from the generator: upper digit in bits 5:3, lower digit in bits 2:0 |
| answer | input | 4 | User answer, binary |
| submit | input | 1 | Submit switch, may bounce |
| elapsed | input | EW | Decisecond count from the external timer |
| tmr_clear | output | 1 | Clear the decisecond timer |
| tmr_run | output | 1 | Let the decisecond timer count |
| pair_req | output | 1 | Request a new digit pair |
| digits_show | output | 1 | Show the digit pair |
| time_show | output | 1 | Show the frozen elapsed time |
| err_code | output | 2 | 0 none, 1 wrong answer, 2 timeout |

## Verification
A corrupted state register or outcome register shows up at the ports in the very next cycle, because all six outputs are decoded from them with no pipeline. The bench runs a behavioural reference of the trial flow and compares every output on every clock. A wrong transition is therefore reported in the cycle it happens. A settle counter that is off by one shifts the moment of the outcome or of the return to blank by exactly one cycle, and the per-cycle comparison catches that.

// File: rtl/quiz_pkg.sv
package quiz_pkg;

    typedef enum logic [3:0] {
        ST_BLANK_CLR    = 4'd0,
        ST_BLANK        = 4'd1,
        ST_REQ          = 4'd2,
        ST_SHOW         = 4'd3,
        ST_CHK_SETTLE   = 4'd4,
        ST_HOLD_HI      = 4'd5,
        ST_LO_SETTLE    = 4'd6,
        ST_LATE_WAIT_HI = 4'd7,
        ST_LATE_SETTLE  = 4'd8
    } quiz_state_e;

    // error code is the outcome value itself for the two failures
    typedef enum logic [1:0] {
        OC_NONE  = 2'd0,
        OC_WRONG = 2'd1,
        OC_LATE  = 2'd2,
        OC_GOOD  = 2'd3
    } outcome_e;

    typedef struct packed {
        logic       clr;
        logic       run;
        logic       req;
        logic       show_d;
        logic       show_t;
        logic [1:0] err;
    } quiz_out_t;

    function automatic logic [3:0] digit_sum(input logic [5:0] pair);
        return {1'b0, pair[5:3]} + {1'b0, pair[2:0]};
    endfunction

    function automatic logic is_settle(input quiz_state_e s);
        return (s == ST_CHK_SETTLE) || (s == ST_LO_SETTLE) || (s == ST_LATE_SETTLE);
    endfunction

endpackage

// File: rtl/quiz_settle_cnt.sv
module quiz_settle_cnt #(
    parameter int SETTLE_CYC = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic done
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (!done) cnt <= cnt + 1'b1;
    end

    // done can only appear after a cycle of counting
    assert_done_after_run_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(!clr));

endmodule

// File: rtl/quiz_answer_check.sv
module quiz_answer_check
    import quiz_pkg::*;
(
    input  logic [5:0] pair,
    input  logic [3:0] answer,
    output logic       match
);
    logic [3:0] sum;
    assign sum   = digit_sum(pair);
    assign match = (answer == sum);
endmodule

// File: rtl/quiz_out_decode.sv
module quiz_out_decode
    import quiz_pkg::*;
(
    input  quiz_state_e st,
    input  outcome_e    oc,
    output quiz_out_t   o
);
    logic showing_outcome;

    always_comb begin
        showing_outcome = (st == ST_HOLD_HI) || (st == ST_LO_SETTLE) ||
                          (st == ST_LATE_WAIT_HI) || (st == ST_LATE_SETTLE);
        o        = '0;
        o.clr    = (st == ST_BLANK_CLR) || (st == ST_REQ);
        o.run    = (st == ST_BLANK) || (st == ST_SHOW);
        o.req    = (st == ST_REQ);
        o.show_d = (st == ST_SHOW) || (st == ST_CHK_SETTLE);
        o.show_t = showing_outcome && (oc == OC_GOOD);
        o.err    = (showing_outcome && oc != OC_GOOD) ? oc : 2'd0;
    end
endmodule

// File: rtl/quiz_timer_ctrl.sv
module quiz_timer_ctrl
    import quiz_pkg::*;
#(
    parameter int EW         = 8,
    parameter int BLANK_DS   = 20,
    parameter int TIMEOUT_DS = 80,
    parameter int SETTLE_CYC = 5_000_000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [5:0]    pair_in,
    input  logic [3:0]    answer,
    input  logic          submit,
    input  logic [EW-1:0] elapsed,
    output logic          tmr_clear,
    output logic          tmr_run,
    output logic          pair_req,
    output logic          digits_show,
    output logic          time_show,
    output logic [1:0]    err_code
);
    localparam logic [EW-1:0] BLANK_LIM = EW'(BLANK_DS);
    localparam logic [EW-1:0] LATE_LIM  = EW'(TIMEOUT_DS);

    quiz_state_e st, st_nxt;
    outcome_e    oc, oc_nxt;
    logic        settle_done, match;
    quiz_out_t   outs;

    quiz_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .clr  (!is_settle(st)),
        .done (settle_done)
    );

    quiz_answer_check u_check (
        .pair   (pair_in),
        .answer (answer),
        .match  (match)
    );

    quiz_out_decode u_dec (
        .st (st),
        .oc (oc),
        .o  (outs)
    );

    always_comb begin
        st_nxt = st;
        oc_nxt = oc;
        case (st)
            ST_BLANK_CLR: begin
                st_nxt = ST_BLANK;
                oc_nxt = OC_NONE;
            end
            ST_BLANK:      if (elapsed >= BLANK_LIM) st_nxt = ST_REQ;
            ST_REQ:        st_nxt = ST_SHOW;
            ST_SHOW: begin
                if (submit) st_nxt = ST_CHK_SETTLE;
                else if (elapsed >= LATE_LIM) begin
                    st_nxt = ST_LATE_WAIT_HI;
                    oc_nxt = OC_LATE;
                end
            end
            ST_CHK_SETTLE: if (settle_done) begin
                st_nxt = ST_HOLD_HI;
                oc_nxt = match ? OC_GOOD : OC_WRONG;
            end
            ST_HOLD_HI:    if (!submit) st_nxt = ST_LO_SETTLE;
            ST_LO_SETTLE: begin
                if (submit) st_nxt = ST_HOLD_HI;
                else if (settle_done) st_nxt = ST_BLANK_CLR;
            end
            ST_LATE_WAIT_HI: if (submit) st_nxt = ST_LATE_SETTLE;
            ST_LATE_SETTLE:  if (settle_done) st_nxt = ST_HOLD_HI;
            default:       st_nxt = ST_BLANK_CLR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_BLANK_CLR;
            oc <= OC_NONE;
        end else begin
            st <= st_nxt;
            oc <= oc_nxt;
        end
    end

    assign tmr_clear   = outs.clr;
    assign tmr_run     = outs.run;
    assign pair_req    = outs.req;
    assign digits_show = outs.show_d;
    assign time_show   = outs.show_t;
    assign err_code    = outs.err;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (tmr_clear && !tmr_run && !pair_req && !digits_show &&
                        !time_show && err_code == 2'd0));

    assert_blank_len_R2: assert property (@(posedge clk) disable iff (rst)
        pair_req |-> $past(elapsed >= BLANK_LIM));

    assert_req_then_show_R3: assert property (@(posedge clk) disable iff (rst)
        pair_req |=> (digits_show && tmr_run));

    assert_req_clears_R3: assert property (@(posedge clk) disable iff (rst)
        pair_req |-> tmr_clear);

    assert_time_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        time_show |-> (!tmr_run && !tmr_clear && err_code == 2'd0));

    assert_late_only_on_timeout_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_code == 2'd2) |-> $past(elapsed >= LATE_LIM));

    assert_timer_ctl_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(tmr_clear && tmr_run));

    assert_err_legal_R11: assert property (@(posedge clk) disable iff (rst)
        err_code != 2'd3);

endmodule

// File: tb/quiz_timer_ctrl_bench.sv
module quiz_timer_ctrl_bench;
    localparam int EW = 8, BLANK_DS = 20, TIMEOUT_DS = 80, SET = 6, TICK = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic [5:0] pair = 6'o26;
    logic [3:0] answer = 4'd0;
    logic submit = 1'b0;
    logic [EW-1:0] elapsed = '0;
    int sub_cnt = 0;
    logic tmr_clear, tmr_run, pair_req, digits_show, time_show;
    logic [1:0] err_code;

    int checks = 0, errors = 0, cyc = 0;

    always #4 clk = ~clk;

    quiz_timer_ctrl #(.EW(EW), .BLANK_DS(BLANK_DS), .TIMEOUT_DS(TIMEOUT_DS), .SETTLE_CYC(SET))
    u_quiz_timer_ctrl (
        .clk(clk), .rst(rst), .pair_in(pair), .answer(answer), .submit(submit),
        .elapsed(elapsed), .tmr_clear(tmr_clear), .tmr_run(tmr_run), .pair_req(pair_req),
        .digits_show(digits_show), .time_show(time_show), .err_code(err_code)
    );

    // external decisecond timer and digit generator
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst || tmr_clear) begin
            elapsed <= '0; sub_cnt <= 0;
        end else if (tmr_run) begin
            if (sub_cnt == TICK - 1) begin
                sub_cnt <= 0;
                if (elapsed != '1) elapsed <= elapsed + 1'b1;
            end else sub_cnt <= sub_cnt + 1;
        end
        if (pair_req) pair <= pair + 6'o13;
    end

    // behavioural reference: phase numbers follow the trial story
    // 0 clear,1 blank,2 request,3 digits,4 answer settle,5 outcome held,
    // 6 release settle,7 timeout await raise,8 timeout raise settle
    int mph = 0, mres = 0, mcnt = 0;
    always @(posedge clk) begin
        int nph; bit settling, fin;
        if (rst) begin mph = 0; mres = 0; mcnt = 0; end
        else begin
            settling = (mph == 4 || mph == 6 || mph == 8);
            fin = (mcnt == SET - 1);
            nph = mph;
            if (mph == 0) begin nph = 1; mres = 0; end
            else if (mph == 1) begin if (elapsed >= BLANK_DS) nph = 2; end
            else if (mph == 2) nph = 3;
            else if (mph == 3) begin
                if (submit) nph = 4;
                else if (elapsed >= TIMEOUT_DS) begin nph = 7; mres = 2; end
            end
            else if (mph == 4) begin
                if (fin) begin
                    nph = 5;
                    mres = (int'(answer) == int'(pair[5:3]) + int'(pair[2:0])) ? 3 : 1;
                end
            end
            else if (mph == 5) begin if (!submit) nph = 6; end
            else if (mph == 6) begin if (submit) nph = 5; else if (fin) nph = 0; end
            else if (mph == 7) begin if (submit) nph = 8; end
            else if (mph == 8) begin if (fin) nph = 5; end
            if (!settling) mcnt = 0; else if (!fin) mcnt = mcnt + 1;
            mph = nph;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            bit outc; int e_err;
            outc = (mph >= 5);
            e_err = (outc && mres != 3) ? mres : 0;
            chk(tmr_clear == (mph == 0 || mph == 2), "R11 model tmr_clear", tmr_clear, 1 - tmr_clear);
            chk(tmr_run == (mph == 1 || mph == 3), "R2 model tmr_run", tmr_run, 1 - tmr_run);
            chk(pair_req == (mph == 2), "R3 model pair_req", pair_req, 1 - pair_req);
            chk(digits_show == (mph == 3 || mph == 4), "R4 model digits_show", digits_show, 1 - digits_show);
            chk(time_show == (outc && mres == 3), "R5 model time_show", time_show, 1 - time_show);
            chk(int'(err_code) == e_err, "R6 model err_code", err_code, e_err);
        end
    end

    task automatic drive(input bit s, input logic [3:0] a);
        @(posedge clk); #1; submit = s; answer = a;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_for(input int which);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (which == 0 && digits_show) return;
            if (which == 1 && (time_show || err_code != 0)) return;
            if (which == 2 && err_code == 2) return;
            if (which == 3 && tmr_clear) return;
        end
    endtask

    function automatic logic [3:0] cur_sum();
        return {1'b0, pair[5:3]} + {1'b0, pair[2:0]};
    endfunction

    initial begin
        repeat (200_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [EW-1:0] frozen;
        repeat (3) @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        // R1: reset state at ports
        chk(tmr_clear && !tmr_run && !digits_show && !time_show && err_code == 0,
            "R1 reset outputs", {tmr_clear, tmr_run, digits_show, time_show}, 4'b1000);

        // correct answer with bouncing submit and a stray answer during settle
        wait_for(0);
        chk(elapsed == 0, "R3 timing restarts with digits", elapsed, 0);
        step(30);
        drive(1, 4'hF); drive(0, 4'hF); drive(1, cur_sum()); drive(0, cur_sum());
        drive(1, cur_sum());
        wait_for(1);
        chk(time_show && err_code == 0, "R4 R10 correct after bounce", err_code, 0);
        frozen = elapsed;
        chk(frozen > 0, "R5 time nonzero", frozen, 1);
        step(12);
        chk(elapsed == frozen && time_show, "R5 time frozen", elapsed, frozen);
        // release with a glitch shorter than settle
        drive(0, 4'd0); drive(0, 4'd0); drive(1, 4'd0); drive(0, 4'd0);
        step(2);
        chk(time_show, "R10 release glitch keeps display", time_show, 1);
        wait_for(3);
        chk(tmr_clear && !time_show && err_code == 0, "R9 back to blank", time_show, 0);
        step(2);
        chk(!digits_show && tmr_run, "R2 blank phase", digits_show, 0);

        // wrong answer
        wait_for(0);
        step(10);
        drive(1, cur_sum() + 4'd1);
        wait_for(1);
        chk(err_code == 1 && !time_show, "R6 wrong answer err", err_code, 1);
        step(10);
        chk(err_code == 1, "R6 held while submit high", err_code, 1);
        drive(0, 4'd0);
        step(SET - 2);
        chk(err_code == 1, "R6 held during release settle", err_code, 1);
        wait_for(3);
        chk(err_code == 0, "R9 wrong cleared", err_code, 0);

        // timeout
        wait_for(0);
        wait_for(2);
        chk(err_code == 2 && elapsed >= TIMEOUT_DS, "R7 timeout err", elapsed, TIMEOUT_DS);
        step(20);
        chk(err_code == 2, "R8 stays without raise", err_code, 2);
        drive(1, 4'd0);
        step(15);
        chk(err_code == 2, "R8 raise alone keeps err", err_code, 2);
        drive(0, 4'd0);
        wait_for(3);
        chk(err_code == 0 && tmr_clear, "R8 R9 raise then lower clears", err_code, 0);

        // correct answer of the largest sum range path: another trial
        wait_for(0);
        drive(1, cur_sum());
        wait_for(1);
        chk(time_show, "R4 immediate submit correct", time_show, 1);
        drive(0, 4'd0);
        wait_for(3);
        step(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule